// File: doc/BRIEF.md
# ASCII Hex Record Stream Loader

This block turns a stream of ASCII text carrying hexadecimal object records into byte writes on a memory port. Characters arrive one per cycle on a valid/ready interface, for example from a serial receiver. Each record is decoded field by field. Data bytes go out as soon as they are assembled, each with a 32-bit absolute address, and every record's checksum is checked when its last digit arrives.

Two kinds of extension record set the address base. A segment record sets the base to a 16-bit value times sixteen. A linear record sets the base to a 16-bit value in the upper half of the address. Start-address records are checked and then dropped. An end record ends the load: `done` rises and no further characters are taken. Checksum and format problems set sticky flags that stay set until reset.

Top module: `hexrec_loader`

## Requirements
- R1: Outside a record, every character other than ':' (0x3A), including CR and LF, is ignored. It sets no flag and causes no write.
- R2: After ':', the loader reads in this order: count byte, offset high byte, offset low byte, type byte, count data bytes, checksum byte. Each byte is two hex digits, most significant digit first. A type 0x00 record writes data byte i to base + ((offset + i) mod 65536). `wr_en` is high for exactly one cycle, the cycle after the second digit of that byte is accepted.
- R3: A record passes when the low byte of the sum of all its bytes, including the checksum, is 0x00; `:0300300002337A1E` passes. On a mismatch, `cksum_err` rises after the last checksum digit and stays set until reset.
- R4: A passing type 0x02 record with count 2 and data S (high byte first) sets the base to S*16.
- R5: A passing type 0x04 record with count 2 and data U (high byte first) sets the base to U*65536. After reset the base is 0.
- R6: A passing type 0x01 record with count 0 raises `done`, which stays set. From the next cycle `ch_ready` is low and no further writes occur.
- R7: Type 0x03 and 0x05 records with count 4 cause no writes and leave the base unchanged.
- R8: Inside a record, the digits 0-9, A-F and a-f are accepted. Any other character sets the sticky `fmt_err` and abandons the record, and no further write occurs until the next ':'.
- R9: A type byte above 0x05 sets `fmt_err` and abandons the record. So does a count that does not fit the type: 0 for type 0x01, 2 for types 0x02 and 0x04, 4 for types 0x03 and 0x05.
- R10: A record whose checksum fails changes neither the base nor `done`.
- R11: A ':' inside a record sets `fmt_err` and starts a new record, which is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Character present |
| ch_data | input | 8 | ASCII character |
| ch_ready | output | 1 | Character accepted when high with ch_valid |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W (32) | Absolute byte address |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | End record seen (sticky) |
| cksum_err | output | 1 | Checksum mismatch seen (sticky) |
| fmt_err | output | 1 | Malformed record seen (sticky) |

## Verification
A data write appears on `wr_en` in the cycle after the clock edge that accepts that byte's second digit. The flags, `done` and the new base all take effect after the edge that accepts the final checksum digit, and `ch_ready` falls in that same following cycle. The bench drives each character at a falling edge and holds it for one cycle. It logs writes and reads the flags only at falling edges, and waits two cycles after the last character of a record before comparing, so every result it checks has already settled.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_COUNT,
      ST_OFFH,
      ST_OFFL,
      ST_TYPE,
      ST_DATA,
      ST_CKS
   } hx_state_e;

   localparam logic [7:0] RT_DATA = 8'h00;
   localparam logic [7:0] RT_EOF  = 8'h01;
   localparam logic [7:0] RT_SEG  = 8'h02;
   localparam logic [7:0] RT_LIN  = 8'h04;
   localparam logic [7:0] RT_MAX  = 8'h05;
   localparam logic [7:0] CH_COLON = 8'h3A;

   // byte count each non-data record type must carry
   function automatic logic [7:0] hx_need_count(input logic [7:0] t);
      case (t)
         RT_EOF:         return 8'd0;
         RT_SEG, RT_LIN: return 8'd2;
         default:        return 8'd4;
      endcase
   endfunction

endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble #(
   parameter bit LOWER_OK = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic [3:0] nib
);
   logic       up_hit;
   logic [3:0] up_nib;
   logic       lo_hit;
   logic [3:0] lo_nib;

   always_comb begin
      up_hit = 1'b0;
      up_nib = 4'h0;
      if (ch >= 8'h30 && ch <= 8'h39) begin
         up_hit = 1'b1;
         up_nib = ch[3:0];
      end else if (ch >= 8'h41 && ch <= 8'h46) begin
         up_hit = 1'b1;
         up_nib = ch[3:0] + 4'd9;
      end
   end

   generate
      if (LOWER_OK) begin : g_lower
         assign lo_hit = (ch >= 8'h61 && ch <= 8'h66);
         assign lo_nib = ch[3:0] + 4'd9;
      end else begin : g_upper_only
         assign lo_hit = 1'b0;
         assign lo_nib = 4'h0;
      end
   endgenerate

   assign is_hex = up_hit | lo_hit;
   assign nib    = up_hit ? up_nib : lo_nib;
endmodule

// File: rtl/hexrec_bytepair.sv
module hexrec_bytepair (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       nib_stb,
   input  logic [3:0] nib,
   output logic       byte_stb,
   output logic [7:0] byte_val
);
   logic       phase_q;
   logic [3:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         hi_q    <= 4'h0;
      end else if (clr) begin
         phase_q <= 1'b0;
      end else if (nib_stb) begin
         if (!phase_q) hi_q <= nib;
         phase_q <= ~phase_q;
      end
   end

   assign byte_stb = nib_stb & phase_q;
   assign byte_val = {hi_q, nib};
endmodule

// File: rtl/hexrec_base.sv
module hexrec_base #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_seg,
   input  logic              set_lin,
   input  logic [15:0]       ext,
   input  logic [15:0]       off,
   output logic [ADDR_W-1:0] addr
);
   logic [31:0] base_q;
   logic [31:0] sum32;

   generate
      if (ADDR_W < 20 || ADDR_W > 32) begin : g_bad_width
         $error("hexrec_base: ADDR_W must be within 20..32");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       base_q <= 32'h0;
      else if (set_seg) base_q <= {12'h000, ext, 4'h0};
      else if (set_lin) base_q <= {ext, 16'h0000};
   end

   assign sum32 = base_q + {16'h0000, off};

   generate
      if (ADDR_W == 32) begin : g_full
         assign addr = sum32;
      end else begin : g_trunc
         assign addr = sum32[ADDR_W-1:0];
      end
   endgenerate

   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_seg || set_lin) |=> $stable(base_q)); // R7
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
   import hexrec_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit LOWER_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_valid,
   input  logic [7:0]        ch_data,
   output logic              ch_ready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              done,
   output logic              cksum_err,
   output logic              fmt_err
);
   hx_state_e         state_q;
   logic [7:0]        cnt_q, left_q, rtype_q, sum_q;
   logic [15:0]       off_q, ext_q;
   logic              done_q, ck_q, fmt_q, wr_en_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [7:0]        wr_data_q;

   logic              acc, colon, in_rec, start, is_hex, nib_stb, bad_ch;
   logic [3:0]        nib;
   logic              byte_stb;
   logic [7:0]        byte_val, sum_next;
   logic              type_bad, cks_ok, set_seg, set_lin;
   logic [ADDR_W-1:0] cur_addr;

   assign acc      = ch_valid & ~done_q;
   assign colon    = (ch_data == CH_COLON);
   assign in_rec   = (state_q != ST_HUNT);
   assign start    = acc & colon;
   assign nib_stb  = acc & in_rec & is_hex;
   assign bad_ch   = acc & in_rec & ~is_hex;
   assign sum_next = sum_q + byte_val;
   assign type_bad = (byte_val > RT_MAX) ||
                     ((byte_val != RT_DATA) && (cnt_q != hx_need_count(byte_val)));
   assign cks_ok   = byte_stb && (state_q == ST_CKS) && (sum_next == 8'h00);
   assign set_seg  = cks_ok && (rtype_q == RT_SEG);
   assign set_lin  = cks_ok && (rtype_q == RT_LIN);

   hexrec_nibble #(.LOWER_OK(LOWER_OK)) nib_i (
      .ch(ch_data), .is_hex(is_hex), .nib(nib)
   );

   hexrec_bytepair pair_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .nib_stb(nib_stb), .nib(nib),
      .byte_stb(byte_stb), .byte_val(byte_val)
   );

   hexrec_base #(.ADDR_W(ADDR_W)) base_i (
      .clk(clk), .rst_n(rst_n), .set_seg(set_seg), .set_lin(set_lin),
      .ext(ext_q), .off(off_q), .addr(cur_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         cnt_q     <= 8'h0;
         left_q    <= 8'h0;
         rtype_q   <= 8'h0;
         sum_q     <= 8'h0;
         off_q     <= 16'h0;
         ext_q     <= 16'h0;
         done_q    <= 1'b0;
         ck_q      <= 1'b0;
         fmt_q     <= 1'b0;
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= 8'h0;
      end else begin
         wr_en_q <= 1'b0;
         if (start) begin
            state_q <= ST_COUNT;
            sum_q   <= 8'h0;
            if (in_rec) fmt_q <= 1'b1;
         end else if (bad_ch) begin
            fmt_q   <= 1'b1;
            state_q <= ST_HUNT;
         end else if (byte_stb) begin
            sum_q <= sum_next;
            case (state_q)
               ST_COUNT: begin
                  cnt_q   <= byte_val;
                  state_q <= ST_OFFH;
               end
               ST_OFFH: begin
                  off_q[15:8] <= byte_val;
                  state_q     <= ST_OFFL;
               end
               ST_OFFL: begin
                  off_q[7:0] <= byte_val;
                  state_q    <= ST_TYPE;
               end
               ST_TYPE: begin
                  rtype_q <= byte_val;
                  left_q  <= cnt_q;
                  if (type_bad) begin
                     fmt_q   <= 1'b1;
                     state_q <= ST_HUNT;
                  end else begin
                     state_q <= (cnt_q == 8'h0) ? ST_CKS : ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (rtype_q == RT_DATA) begin
                     wr_en_q   <= 1'b1;
                     wr_addr_q <= cur_addr;
                     wr_data_q <= byte_val;
                  end
                  ext_q  <= {ext_q[7:0], byte_val};
                  off_q  <= off_q + 16'd1;
                  left_q <= left_q - 8'd1;
                  if (left_q == 8'd1) state_q <= ST_CKS;
               end
               ST_CKS: begin
                  if (sum_next != 8'h00) ck_q <= 1'b1;
                  else if (rtype_q == RT_EOF) done_q <= 1'b1;
                  state_q <= ST_HUNT;
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign ch_ready  = ~done_q;
   assign wr_en     = wr_en_q;
   assign wr_addr   = wr_addr_q;
   assign wr_data   = wr_data_q;
   assign done      = done_q;
   assign cksum_err = ck_q;
   assign fmt_err   = fmt_q;

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q); // R6
   AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !wr_en_q); // R6
   AST_CKERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ck_q |=> ck_q); // R3
   AST_FMT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_q |=> fmt_q); // R8
   AST_NO_WR_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT) |=> !wr_en_q); // R1
endmodule

// File: tb/hexrec_loader_tb_top.sv
module hexrec_loader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ch_valid = 1'b0;
   logic [7:0]  ch_data = 8'h0;
   logic        ch_ready, wr_en, done, cksum_err, fmt_err;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;

   int checks = 0;
   int failures = 0;
   int wn = 0;
   logic [31:0] wa [0:511];
   logic [7:0]  wd [0:511];
   logic [7:0]  tx [0:255];
   logic [31:0] exp_base;

   always #10 clk = ~clk;

   hexrec_loader dut_i (
      .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
      .ch_ready(ch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err)
   );

   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (wn < 512) begin
            wa[wn] = wr_addr;
            wd[wn] = wr_data;
         end
         wn = wn + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ch_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wn = 0;
      exp_base = 32'h0;
   endtask

   task automatic put(input logic [7:0] c);
      @(negedge clk);
      ch_valid = 1'b1;
      ch_data  = c;
      @(negedge clk);
      ch_valid = 1'b0;
   endtask

   function automatic logic [7:0] hexc(input logic [3:0] n, input bit lo);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lo ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
   endfunction

   task automatic put_byte(input logic [7:0] b, input bit lo);
      put(hexc(b[7:4], lo));
      put(hexc(b[3:0], lo));
   endtask

   task automatic send_rec(input logic [7:0] cnt, input logic [15:0] off,
                           input logic [7:0] typ, input bit lo, input bit corrupt);
      logic [7:0] s;
      s = cnt + off[15:8] + off[7:0] + typ;
      put(8'h3A);
      put_byte(cnt, lo);
      put_byte(off[15:8], lo);
      put_byte(off[7:0], lo);
      put_byte(typ, lo);
      for (int i = 0; i < cnt; i++) begin
         put_byte(tx[i], lo);
         s = s + tx[i];
      end
      s = 8'h00 - s;
      if (corrupt) s = s ^ 8'h01;
      put_byte(s, lo);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_writes(input int first, input int n, input logic [15:0] off, input string tag);
      logic [15:0] o;
      chk(wn == first + n, {tag, " write count"}, wn, first + n);
      for (int i = 0; i < n; i++) begin
         o = off + i[15:0];
         chk(wa[first+i] == exp_base + {16'h0, o}, {tag, " addr"}, wa[first+i], exp_base + {16'h0, o});
         chk(wd[first+i] == tx[i], {tag, " data"}, {24'h0, wd[first+i]}, {24'h0, tx[i]});
      end
   endtask

   function automatic bit is_hexch(input logic [7:0] c);
      return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66);
   endfunction

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog expired R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int base_wn;
      do_reset();
      // reset state (R6, R5)
      chk(!wr_en && !done && !cksum_err && !fmt_err, "R6 reset outputs", {wr_en, done, cksum_err, fmt_err}, 0);
      chk(ch_ready == 1'b1, "R6 ready after reset", ch_ready, 1);

      // R1: junk before a record
      put(8'h0D); put(8'h0A); put("Z"); put("7"); put("a"); put(8'h00);
      @(negedge clk);
      chk(wn == 0 && !fmt_err && !cksum_err, "R1 junk ignored", {wn[29:0], fmt_err, cksum_err}, 0);

      // R3/R2: the reference-style example record, checksum 1E
      tx[0] = 8'h02; tx[1] = 8'h33; tx[2] = 8'h7A;
      chk((8'h00 - (8'h03 + 8'h30 + 8'h02 + 8'h33 + 8'h7A)) == 8'h1E, "R3 sum arithmetic", 0, 0);
      send_rec(8'h03, 16'h0030, 8'h00, 1'b0, 1'b0);
      chk(!cksum_err, "R3 example passes", cksum_err, 0);
      check_writes(0, 3, 16'h0030, "R2 example");

      // R2/R8: sweep counts and offsets, mixing digit case
      for (int n = 1; n <= 16; n++) begin
         base_wn = wn;
         for (int i = 0; i < n; i++) tx[i] = n[7:0] * 8'd7 + i[7:0] * 8'd29;
         send_rec(n[7:0], n[15:0] * 16'h0ABC, 8'h00, n[0], 1'b0);
         check_writes(base_wn, n, n[15:0] * 16'h0ABC, "R2 R8 sweep");
      end
      // R2: offset wrap within 16 bits
      base_wn = wn;
      for (int i = 0; i < 4; i++) tx[i] = 8'hC0 + i[7:0];
      send_rec(8'd4, 16'hFFFE, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 4, 16'hFFFE, "R2 wrap");

      // R4: segment base
      tx[0] = 8'h12; tx[1] = 8'h30;
      base_wn = wn;
      send_rec(8'd2, 16'h0000, 8'h02, 1'b0, 1'b0);
      chk(wn == base_wn, "R4 no write", wn, base_wn);
      exp_base = 32'h0001_2300;
      base_wn = wn;
      tx[0] = 8'h5A; tx[1] = 8'hA5;
      send_rec(8'd2, 16'h0005, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 2, 16'h0005, "R4 seg");

      // R5: linear base
      tx[0] = 8'hAB; tx[1] = 8'hCD;
      send_rec(8'd2, 16'h0000, 8'h04, 1'b1, 1'b0);
      exp_base = 32'hABCD_0000;
      base_wn = wn;
      tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
      send_rec(8'd3, 16'h1234, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 3, 16'h1234, "R5 lin");

      // R7: start-address records
      base_wn = wn;
      tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h03; tx[3] = 8'h04;
      send_rec(8'd4, 16'h0000, 8'h03, 1'b0, 1'b0);
      send_rec(8'd4, 16'h0000, 8'h05, 1'b0, 1'b0);
      chk(wn == base_wn && !fmt_err && !cksum_err, "R7 no writes", wn, base_wn);
      tx[0] = 8'h77;
      send_rec(8'd1, 16'h0040, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 1, 16'h0040, "R7 base kept");

      // R3/R10: bad checksum on a linear record
      tx[0] = 8'h55; tx[1] = 8'h55;
      send_rec(8'd2, 16'h0000, 8'h04, 1'b0, 1'b1);
      chk(cksum_err == 1'b1, "R3 mismatch flagged", cksum_err, 1);
      base_wn = wn;
      tx[0] = 8'h99;
      send_rec(8'd1, 16'h0002, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 1, 16'h0002, "R10 base unchanged");
      chk(cksum_err == 1'b1, "R3 flag sticky", cksum_err, 1);
      // R10: bad-checksum end record does not finish
      send_rec(8'd0, 16'h0000, 8'h01, 1'b0, 1'b1);
      chk(!done && ch_ready, "R10 no done", done, 0);

      // R9: illegal type, and count mismatch
      do_reset();
      send_rec(8'd0, 16'h0000, 8'h07, 1'b0, 1'b0);
      chk(fmt_err == 1'b1, "R9 type 07", fmt_err, 1);
      do_reset();
      tx[0] = 8'h10; tx[1] = 8'h00; tx[2] = 8'h00;
      send_rec(8'd3, 16'h0000, 8'h02, 1'b0, 1'b0);
      chk(fmt_err == 1'b1, "R9 seg count 3", fmt_err, 1);
      tx[0] = 8'h44;
      base_wn = wn;
      send_rec(8'd1, 16'h0008, 8'h00, 1'b0, 1'b0);
      check_writes(base_wn, 1, 16'h0008, "R9 base untouched");

      // R8: bad char during data abandons record
      do_reset();
      put(8'h3A); put_byte(8'h03, 0); put_byte(8'h00, 0); put_byte(8'h10, 0); put_byte(8'h00, 0);
      put_byte(8'hAB, 0); put("G"); put_byte(8'hCD, 0); put_byte(8'hEF, 0);
      @(negedge clk); @(negedge clk);
      chk(fmt_err == 1'b1, "R8 bad char flag", fmt_err, 1);
      chk(wn == 1, "R8 writes stop", wn, 1);
      chk(wd[0] == 8'hAB, "R8 first byte kept", wd[0], 8'hAB);

      // R11: colon inside a record restarts
      do_reset();
      put(8'h3A); put_byte(8'h10, 0); put("0");
      tx[0] = 8'h61; tx[1] = 8'h62;
      send_rec(8'd2, 16'h0200, 8'h00, 1'b0, 1'b0);
      chk(fmt_err == 1'b1, "R11 flag", fmt_err, 1);
      chk(!cksum_err, "R11 new record checks", cksum_err, 0);
      check_writes(0, 2, 16'h0200, "R11 restart");

      // R1/R8: all 256 characters, outside and inside a record
      for (int c = 0; c < 256; c++) begin
         do_reset();
         if (c != 8'h3A) begin
            put(c[7:0]);
            @(negedge clk);
            chk(!fmt_err && wn == 0, "R1 char outside", {c[23:0], 7'h0, fmt_err}, {c[23:0], 8'h0});
         end
         put(8'h3A); put("0"); put(c[7:0]);
         @(negedge clk);
         chk(fmt_err == !is_hexch(c[7:0]), "R8 char inside", {c[23:0], 7'h0, fmt_err}, {c[23:0], 7'h0, !is_hexch(c[7:0])});
      end

      // R6: end record
      do_reset();
      send_rec(8'd0, 16'h0000, 8'h01, 1'b0, 1'b0);
      chk(done == 1'b1, "R6 done", done, 1);
      chk(ch_ready == 1'b0, "R6 ready low", ch_ready, 0);
      tx[0] = 8'hEE;
      send_rec(8'd1, 16'h0000, 8'h00, 1'b0, 1'b0);
      chk(wn == 0 && done, "R6 nothing after done", wn, 0);
      chk(!fmt_err && !cksum_err, "R6 flags clean", {fmt_err, cksum_err}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule